// File: doc/BRIEF.md
# Burst beat address generator

This block turns one burst request into the sequence of per-beat addresses that a memory-mapped target needs. A request carries a start address, a three-bit size code (bytes per beat), an eight-bit length field (beats minus one) and a two-bit burst-type code. Once it is accepted, the block presents one beat address at a time on a VALID/READY output. Each accepted beat moves it to the next address, and the final beat carries a last flag.

Three burst types are supported: fixed, incrementing and wrapping. Requests are checked for legality when they are accepted. Reserved type codes, lengths not allowed for the type, misaligned wrapping starts and incrementing bursts that would run past a 4 KB page are all rejected. A rejected request produces no beats and raises a one-cycle error pulse. The data path, strobes, responses and ID handling belong to neighbouring logic.

Top module: `burst_addr_gen`

## Requirements
- R1: A legal request with length field L yields exactly L+1 beats; `beat_last_o` is high on the final beat only, and `beat_valid_o` falls in the cycle after the final beat is taken.
- R2: Size code S means 2^S bytes per beat (1 to 128); in an incrementing burst, consecutive beat addresses after the first differ by exactly 2^S.
- R3: Type code 2'b00 (fixed): every beat address equals the start address.
- R4: Type code 2'b01 (incrementing): beat 0 is the raw start address; beat i>0 is the start rounded down to a multiple of 2^S, plus i*2^S, so an unaligned start is realigned from beat 1 on.
- R5: Type code 2'b10 (wrapping): with total T = (L+1)*2^S and base = start rounded down to a multiple of T, beat i is base + ((start - base + i*2^S) mod T). With S=2, L=7 and start 0x08, the sequence is 0x08,0x0C,0x10,0x14,0x18,0x1C,0x00,0x04.
- R6: A wrapping request is illegal unless L is 1, 3, 7 or 15 and the start is a multiple of 2^S.
- R7: A fixed request with L above 15 is illegal.
- R8: An incrementing request is illegal when its last byte (aligned start + (L+1)*2^S - 1) lies in a different 4 KB page (address bits above bit 11) than the start.
- R9: Type code 2'b11 is reserved and always illegal.
- R10: `req_ready_o` is high exactly when no burst is in progress (so it is high after reset, with `beat_valid_o` and `err_o` low). While `beat_valid_o` is high and `beat_ready_i` is low, the beat address and flags hold.
- R11: An illegal request is still accepted. It produces no beats, and `err_o` is high for exactly the one cycle after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Burst request present |
| req_ready_o | output | 1 | Block idle, request can be taken |
| req_addr_i | input | ADDR_W | Start address |
| req_size_i | input | SIZE_W | Beat size code, 2^code bytes |
| req_len_i | input | LEN_W | Beat count minus one |
| req_type_i | input | 2 | 00 fixed, 01 incrementing, 10 wrapping, 11 reserved |
| beat_valid_o | output | 1 | Beat address present |
| beat_ready_i | input | 1 | Beat address taken |
| beat_addr_o | output | ADDR_W | Current beat address |
| beat_last_o | output | 1 | Final beat of the burst |
| err_o | output | 1 | One-cycle pulse after an illegal request is accepted |

## Verification
The hardest behaviour to reach from the ports combines a burst's final beats with a page limit or a wrap point, hit at the same time as a stall on the beat output. The bench sweeps every size code and every type code against lengths at and around 0, 1, 15, 16 and 255. It uses start offsets that are aligned, unaligned, at a wrap-container edge and just below a 4 KB page end. While the beats stream, it pulls ready low on a rotating pattern so that stalls land on wrap transitions and on final beats.

// File: rtl/burst_pkg.sv
package burst_pkg;
  typedef enum logic [1:0] {
    BT_FIXED = 2'b00,
    BT_INCR  = 2'b01,
    BT_WRAP  = 2'b10,
    BT_RSVD  = 2'b11
  } burst_type_e;
endpackage

// File: rtl/burst_legal.sv
module burst_legal
  import burst_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 8,
  parameter int SIZE_W = 3,
  parameter int PAGE_W = 12
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [SIZE_W-1:0] size_i,
  input  logic [LEN_W-1:0]  len_i,
  input  burst_type_e       type_i,
  output logic              legal_o
);
  localparam int XW = ADDR_W + 1;

  logic [ADDR_W-1:0] size_mask, aligned;
  logic [XW-1:0]     span, last_byte;
  logic              crosses, wrap_len_ok, long_len;

  always_comb begin
    size_mask   = (ADDR_W'(1) << size_i) - ADDR_W'(1);
    aligned     = addr_i & ~size_mask;
    span        = (XW'(len_i) + XW'(1)) << size_i;
    last_byte   = {1'b0, aligned} + span - XW'(1);
    crosses     = (last_byte >> PAGE_W) != ({1'b0, addr_i} >> PAGE_W);
    wrap_len_ok = (len_i == LEN_W'(1)) || (len_i == LEN_W'(3)) ||
                  (len_i == LEN_W'(7)) || (len_i == LEN_W'(15));
    long_len    = len_i > LEN_W'(15);
    unique case (type_i)
      BT_FIXED: legal_o = !long_len;
      BT_INCR:  legal_o = !crosses;
      BT_WRAP:  legal_o = wrap_len_ok && ((addr_i & size_mask) == '0);
      default:  legal_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/burst_step.sv
module burst_step
  import burst_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SIZE_W = 3
) (
  input  logic [ADDR_W-1:0] cur_i,
  input  logic [SIZE_W-1:0] size_i,
  input  burst_type_e       type_i,
  input  logic [ADDR_W-1:0] wrap_mask_i,
  output logic [ADDR_W-1:0] next_o
);
  logic [ADDR_W-1:0] bytes, size_mask, inc_addr, wrap_addr;

  always_comb begin
    bytes     = ADDR_W'(1) << size_i;
    size_mask = bytes - ADDR_W'(1);
    // realign first, so an unaligned start snaps to the grid
    inc_addr  = (cur_i & ~size_mask) + bytes;
    wrap_addr = (cur_i & ~wrap_mask_i) | ((cur_i + bytes) & wrap_mask_i);
    unique case (type_i)
      BT_INCR: next_o = inc_addr;
      BT_WRAP: next_o = wrap_addr;
      default: next_o = cur_i;
    endcase
  end
endmodule

// File: rtl/burst_seq.sv
module burst_seq
  import burst_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 8,
  parameter int SIZE_W = 3,
  parameter int PAGE_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [SIZE_W-1:0] req_size_i,
  input  logic [LEN_W-1:0]  req_len_i,
  input  burst_type_e       req_type_i,
  input  logic              legal_i,
  input  logic [ADDR_W-1:0] next_addr_i,
  output logic [ADDR_W-1:0] cur_addr_o,
  output logic [SIZE_W-1:0] size_o,
  output burst_type_e       type_o,
  output logic [ADDR_W-1:0] wrap_mask_o,
  output logic              beat_valid_o,
  input  logic              beat_ready_i,
  output logic              beat_last_o,
  output logic              err_o
);
  logic              active_q, err_q;
  logic [LEN_W-1:0]  left_q;
  logic [ADDR_W-1:0] cur_q, mask_q, page_q;
  logic [SIZE_W-1:0] size_q;
  burst_type_e       type_q;
  logic              req_fire, beat_fire, last;

  assign req_ready_o  = !active_q;
  assign req_fire     = req_valid_i && req_ready_o;
  assign beat_valid_o = active_q;
  assign last         = (left_q == '0);
  assign beat_last_o  = active_q && last;
  assign beat_fire    = active_q && beat_ready_i;
  assign cur_addr_o   = cur_q;
  assign size_o       = size_q;
  assign type_o       = type_q;
  assign wrap_mask_o  = mask_q;
  assign err_o        = err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      err_q    <= 1'b0;
      left_q   <= '0;
      cur_q    <= '0;
      mask_q   <= '0;
      page_q   <= '0;
      size_q   <= '0;
      type_q   <= BT_FIXED;
    end else begin
      err_q <= req_fire && !legal_i;
      if (req_fire && legal_i) begin
        active_q <= 1'b1;
        cur_q    <= req_addr_i;
        left_q   <= req_len_i;
        size_q   <= req_size_i;
        type_q   <= req_type_i;
        page_q   <= req_addr_i >> PAGE_W;
        mask_q   <= ((ADDR_W'(req_len_i) + ADDR_W'(1)) << req_size_i) - ADDR_W'(1);
      end else if (beat_fire) begin
        if (last) begin
          active_q <= 1'b0;
        end else begin
          cur_q  <= next_addr_i;
          left_q <= left_q - LEN_W'(1);
        end
      end
    end
  end

  assert_last_ends_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    beat_fire && last |=> !beat_valid_o);
  assert_mid_continues_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    beat_fire && !last |=> beat_valid_o);
  assert_stall_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    beat_valid_o && !beat_ready_i |=> beat_valid_o && $stable(cur_q) && $stable(beat_last_o));
  assert_fixed_same_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    beat_fire && !last && type_q == BT_FIXED |=> $stable(cur_q));
  assert_in_page_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_q |-> (cur_q >> PAGE_W) == page_q);
  assert_err_after_accept_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_q |-> $past(req_valid_i && req_ready_o) && !active_q);
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 8,
  parameter int SIZE_W = 3,
  parameter int PAGE_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [SIZE_W-1:0] req_size_i,
  input  logic [LEN_W-1:0]  req_len_i,
  input  logic [1:0]        req_type_i,
  output logic              beat_valid_o,
  input  logic              beat_ready_i,
  output logic [ADDR_W-1:0] beat_addr_o,
  output logic              beat_last_o,
  output logic              err_o
);
  logic              legal;
  logic [ADDR_W-1:0] cur_addr, next_addr, wrap_mask;
  logic [SIZE_W-1:0] size_q;
  burst_type_e       type_q, req_type;

  assign req_type    = burst_type_e'(req_type_i);
  assign beat_addr_o = cur_addr;

  burst_legal #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .SIZE_W(SIZE_W), .PAGE_W(PAGE_W)) u_legal (
    .addr_i (req_addr_i),
    .size_i (req_size_i),
    .len_i  (req_len_i),
    .type_i (req_type),
    .legal_o(legal)
  );

  burst_step #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) u_step (
    .cur_i      (cur_addr),
    .size_i     (size_q),
    .type_i     (type_q),
    .wrap_mask_i(wrap_mask),
    .next_o     (next_addr)
  );

  burst_seq #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .SIZE_W(SIZE_W), .PAGE_W(PAGE_W)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .req_ready_o (req_ready_o),
    .req_addr_i  (req_addr_i),
    .req_size_i  (req_size_i),
    .req_len_i   (req_len_i),
    .req_type_i  (req_type),
    .legal_i     (legal),
    .next_addr_i (next_addr),
    .cur_addr_o  (cur_addr),
    .size_o      (size_q),
    .type_o      (type_q),
    .wrap_mask_o (wrap_mask),
    .beat_valid_o(beat_valid_o),
    .beat_ready_i(beat_ready_i),
    .beat_last_o (beat_last_o),
    .err_o       (err_o)
  );
endmodule

// File: tb/burst_addr_gen_tb.sv
module burst_addr_gen_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic [2:0]  req_size = '0;
  logic [7:0]  req_len = '0;
  logic [1:0]  req_type = '0;
  logic        beat_valid;
  logic        beat_ready = 1'b1;
  logic [31:0] beat_addr;
  logic        beat_last;
  logic        err;

  int total = 0;
  int bad   = 0;
  int stall_ctr = 0;

  always #5 clk = ~clk;

  burst_addr_gen dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_addr_i(req_addr), .req_size_i(req_size), .req_len_i(req_len), .req_type_i(req_type),
    .beat_valid_o(beat_valid), .beat_ready_i(beat_ready),
    .beat_addr_o(beat_addr), .beat_last_o(beat_last), .err_o(err)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic bit legal_f(longint a, int sz, int ln, int ty);
    longint by = longint'(1) << sz;
    longint al = a - (a % by);
    longint lb = al + longint'(ln + 1) * by - 1;
    case (ty)
      0: return ln <= 15;
      1: return (a >> 12) == (lb >> 12);
      2: return (ln == 1 || ln == 3 || ln == 7 || ln == 15) && (a % by == 0);
      default: return 1'b0;
    endcase
  endfunction

  function automatic longint exp_addr(longint a, int sz, int ln, int ty, int i);
    longint by = longint'(1) << sz;
    longint tot = longint'(ln + 1) * by;
    longint base = a - (a % tot);
    case (ty)
      0: return a;
      1: return (i == 0) ? a : (a - (a % by)) + longint'(i) * by;
      default: return base + ((a - base + longint'(i) * by) % tot);
    endcase
  endfunction

  function automatic string illegal_tag(int ty);
    case (ty)
      0: return "R7";
      1: return "R8";
      2: return "R6";
      default: return "R9";
    endcase
  endfunction

  function automatic string type_tag(int ty);
    case (ty)
      0: return "R3";
      1: return "R4 R2";
      default: return "R5";
    endcase
  endfunction

  task automatic run_burst(input longint a, input int sz, input int ln, input int ty);
    bit lg = legal_f(a, sz, ln, ty);
    @(negedge clk);
    chk(req_ready == 1'b1, "R10 idle ready", longint'(req_ready), 1);
    req_valid = 1'b1;
    req_addr  = 32'(a);
    req_size  = 3'(sz);
    req_len   = 8'(ln);
    req_type  = 2'(ty);
    @(negedge clk);
    req_valid = 1'b0;
    if (!lg) begin
      chk(err == 1'b1 && beat_valid == 1'b0, {illegal_tag(ty), " R11 reject"},
          longint'({err, beat_valid}), 2);
      @(negedge clk);
      chk(err == 1'b0 && beat_valid == 1'b0 && req_ready == 1'b1, "R11 single pulse",
          longint'({err, beat_valid, req_ready}), 1);
      return;
    end
    chk(err == 1'b0, "R11 no error on legal", longint'(err), 0);
    for (int i = 0; i <= ln; i++) begin
      longint e = exp_addr(a, sz, ln, ty, i);
      chk(beat_valid == 1'b1 && beat_addr == 32'(e), type_tag(ty), longint'(beat_addr), e);
      chk(beat_last == (i == ln), "R1 last flag", longint'(beat_last), longint'(i == ln));
      if (i == 0) chk(req_ready == 1'b0, "R10 busy", longint'(req_ready), 0);
      stall_ctr++;
      if (stall_ctr % 3 == 1) begin
        beat_ready = 1'b0;
        @(negedge clk);
        chk(beat_valid == 1'b1 && beat_addr == 32'(e) && beat_last == (i == ln),
            "R10 stall hold", longint'(beat_addr), e);
        beat_ready = 1'b1;
      end
      @(negedge clk);
    end
    chk(beat_valid == 1'b0 && req_ready == 1'b1, "R1 burst ended",
        longint'({beat_valid, req_ready}), 1);
  endtask

  initial begin
    #1_900_000;
    total++;
    bad++;
    $display("FAIL watchdog actual=0x0 expected=0x1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    longint offs[6] = '{64'h000, 64'h007, 64'h008, 64'h040, 64'hF80, 64'hFFC};
    int     lens[8] = '{0, 1, 2, 3, 7, 15, 16, 255};
    repeat (3) @(negedge clk);
    chk(req_ready == 1'b1 && beat_valid == 1'b0 && err == 1'b0, "R10 reset state",
        longint'({req_ready, beat_valid, err}), 4);
    rst_n = 1'b1;
    // R5 reference wrap sequence at absolute start 0x08
    run_burst(64'h8, 2, 7, 2);
    for (int ty = 0; ty < 4; ty++)
      for (int sz = 0; sz < 8; sz++)
        for (int li = 0; li < 8; li++)
          for (int oi = 0; oi < 6; oi++)
            run_burst(64'h0003_0000 + offs[oi], sz, lens[li], ty);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule